// File: doc/BRIEF.md
# Remote reconfiguration controller with fallback watchdog

This block sits beside the configuration logic of a device that holds two images in its configuration memory: a factory image at byte address zero and a user image elsewhere. Software uses a small register-style slave port to stage a boot address, a watchdog timeout and a watchdog enable. It reads those values back to confirm them, and then triggers a reconfiguration. The parameters live in three sets: pending (written by software), current (in force) and previous (the set that was in force before the last switch). A two-bit read-source selector chooses which set a read returns.

On a trigger the controller shifts the sets along: current goes to previous and pending goes to current. For one cycle it raises a reconfiguration request that carries the full byte address. If the new current set enables the watchdog and points at a user image, a countdown starts. The stored timeout forms the upper bits of that count and the low bits start at zero. The running image must kick the watchdog before the count runs out. If it does not, the controller drops the current set back to the factory values, records the event in a sticky status bit and requests a reload from address zero.

The state machine has five states. FACTORY means the factory image is running and the watchdog is idle. LAUNCH is the one-cycle request for a software trigger. USER means a user image is running unwatched. ARMED means a user image is running with the countdown active. FALLBACK is the one-cycle request to address zero. The transitions are:
- trigger: FACTORY, USER or ARMED to LAUNCH.
- launch-to-factory: LAUNCH to FACTORY when the new address is zero.
- launch-to-user: LAUNCH to USER when the new address is nonzero and the watchdog is off.
- launch-to-armed: LAUNCH to ARMED when the new address is nonzero and the watchdog is on.
- expiry: ARMED to FALLBACK.
- fallback-done: FALLBACK to FACTORY.

Top module: `remote_reconfig_ctrl`

## Requirements
- R1: After synchronous reset every set holds address 0, timeout 0 and enable 0, status reads 0, the state is FACTORY and no request is raised.
- R2: A write updates the pending set only when `bus_rsel` is 00. With any other selector value a write leaves the pending set unchanged.
- R3: Register indices are 0 boot address, 1 watchdog timeout, 2 watchdog enable (bit 0), 3 reconfigure (bit 0) and 4 status. For indices 0 to 2, a read returns the current set with selector 00, the previous set with 01 and the pending set with 11, and returns 0 with selector 10. Indices 3, 5, 6 and 7 read 0. Read data appears on `bus_rdata` on the clock edge that samples `bus_re` and holds until the next read.
- R4: The boot address register holds BOOT_W bits, equal to the byte address shifted right by two. The request address is the stored value shifted left by two, so a stored 0x20000 is requested as 0x80000.
- R5: The timeout register keeps only its low WDT_HI_W bits, and the enable register keeps only bit 0. Higher write-data bits are dropped.
- R6: Writing 1 in bit 0 of register 3 triggers a reconfiguration whatever the selector value. The trigger copies current into previous and pending into current. In the next cycle `reconfig_req` is high for exactly one cycle with the new byte address. Writing 0 to register 3 has no effect. Triggers are ignored in the LAUNCH and FALLBACK cycles. If a trigger and an expiry occur in the same ARMED cycle, the trigger wins.
- R7: When the new current set has enable 1 and a nonzero address, the countdown start is {timeout, WDT_LO_W zeros}. Without a kick, a fallback request to byte address 0 appears exactly start+2 cycles after the launch request.
- R8: A high `wdt_kick` in ARMED reloads the count to its start value. Kicks spaced closer than start+1 cycles prevent any fallback.
- R9: On fallback the current set becomes address 0, timeout 0, enable 0 and the previous set takes the user set that failed. Status bit 0 (fired) is then set and stays set until reset. Status bit 1 reads 1 only in ARMED.
- R10: No fallback occurs when the new current set has enable 0 or address 0, and status bit 1 then stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 3 | Register index |
| bus_rsel | input | 2 | Read-source selector, also the write gate |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| wdt_kick | input | 1 | Watchdog kick from the running image |
| reconfig_req | output | 1 | One-cycle reconfiguration request |
| reconfig_addr | output | BOOT_W+2 | Byte address that goes with the request |

## Verification
The bench builds the block with WDT_LO_W set to 4 and every other parameter at its default. A timeout of 3 then gives a start count of 48, so an expiry, a run of kicks and the exact start+2 fallback latency can all be checked within a few hundred cycles. With the default low width a single expiry would take hundreds of thousands of cycles. The full 23-bit address and the 12-bit timeout field keep their default widths, so the shift-by-two mapping and the dropping of high write bits are exercised at their real sizes.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;

    localparam int REG_AW = 3;

    typedef enum logic [2:0] {
        RID_BOOT   = 3'd0,
        RID_WDT    = 3'd1,
        RID_ENA    = 3'd2,
        RID_RECONF = 3'd3,
        RID_STATUS = 3'd4
    } reg_id_e;

    typedef enum logic [1:0] {
        RS_CUR  = 2'b00,
        RS_PREV = 2'b01,
        RS_NONE = 2'b10,
        RS_PEND = 2'b11
    } rsel_e;

    typedef enum logic [2:0] {
        ST_FACTORY  = 3'd0,
        ST_LAUNCH   = 3'd1,
        ST_USER     = 3'd2,
        ST_ARMED    = 3'd3,
        ST_FALLBACK = 3'd4
    } seq_state_e;

    localparam int NSETS    = 3;
    localparam int SET_CUR  = 0;
    localparam int SET_PREV = 1;
    localparam int SET_PEND = 2;

    localparam int STAT_FIRED = 0;
    localparam int STAT_ARMED = 1;

endpackage

// File: rtl/rcfg_param_sets.sv
module rcfg_param_sets
    import rcfg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BOOT_W   = 23,
    parameter int WDT_HI_W = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [REG_AW-1:0]   wr_reg,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic                rd_en,
    input  logic [REG_AW-1:0]   rd_reg,
    input  logic [1:0]          rd_src,
    input  logic                commit,
    input  logic                revert,
    input  logic                st_fired,
    input  logic                st_armed,
    output logic [DATA_W-1:0]   rdata,
    output logic [BOOT_W-1:0]   cur_addr,
    output logic [WDT_HI_W-1:0] cur_tmo,
    output logic                cur_en,
    output logic [BOOT_W-1:0]   pend_addr
);

    logic [BOOT_W-1:0]   set_addr [NSETS];
    logic [WDT_HI_W-1:0] set_tmo  [NSETS];
    logic                set_en   [NSETS];
    logic [DATA_W-1:0]   set_word [NSETS];

    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wr_data[DATA_W-1:BOOT_W];

    function automatic logic [DATA_W-1:0] field_word(
        input logic [BOOT_W-1:0]   a,
        input logic [WDT_HI_W-1:0] t,
        input logic                e,
        input logic [REG_AW-1:0]   r
    );
        logic [DATA_W-1:0] w;
        w = '0;
        case (r)
            RID_BOOT: w[BOOT_W-1:0]   = a;
            RID_WDT:  w[WDT_HI_W-1:0] = t;
            RID_ENA:  w[0]            = e;
            default:  w               = '0;
        endcase
        return w;
    endfunction

    // Parameter sets: pending takes writes, commit/revert move the others
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) begin
                set_addr[s] <= '0;
                set_tmo[s]  <= '0;
                set_en[s]   <= 1'b0;
            end
        end else begin
            if (commit) begin
                set_addr[SET_PREV] <= set_addr[SET_CUR];
                set_tmo[SET_PREV]  <= set_tmo[SET_CUR];
                set_en[SET_PREV]   <= set_en[SET_CUR];
                set_addr[SET_CUR]  <= set_addr[SET_PEND];
                set_tmo[SET_CUR]   <= set_tmo[SET_PEND];
                set_en[SET_CUR]    <= set_en[SET_PEND];
            end else if (revert) begin
                set_addr[SET_PREV] <= set_addr[SET_CUR];
                set_tmo[SET_PREV]  <= set_tmo[SET_CUR];
                set_en[SET_PREV]   <= set_en[SET_CUR];
                set_addr[SET_CUR]  <= '0;
                set_tmo[SET_CUR]   <= '0;
                set_en[SET_CUR]    <= 1'b0;
            end
            if (wr_en) begin
                case (wr_reg)
                    RID_BOOT: set_addr[SET_PEND] <= wr_data[BOOT_W-1:0];
                    RID_WDT:  set_tmo[SET_PEND]  <= wr_data[WDT_HI_W-1:0];
                    RID_ENA:  set_en[SET_PEND]   <= wr_data[0];
                    default:  ;
                endcase
            end
        end
    end

    // One read word per set for the addressed register
    for (genvar g = 0; g < NSETS; g++) begin : g_set_word
        assign set_word[g] = field_word(set_addr[g], set_tmo[g], set_en[g], rd_reg);
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (rd_reg == RID_STATUS) begin
                rdata             <= '0;
                rdata[STAT_FIRED] <= st_fired;
                rdata[STAT_ARMED] <= st_armed;
            end else begin
                case (rd_src)
                    RS_CUR:  rdata <= set_word[SET_CUR];
                    RS_PREV: rdata <= set_word[SET_PREV];
                    RS_PEND: rdata <= set_word[SET_PEND];
                    default: rdata <= '0;
                endcase
            end
        end
    end

    assign cur_addr  = set_addr[SET_CUR];
    assign cur_tmo   = set_tmo[SET_CUR];
    assign cur_en    = set_en[SET_CUR];
    assign pend_addr = set_addr[SET_PEND];

endmodule

// File: rtl/rcfg_watchdog.sv
module rcfg_watchdog #(
    parameter int WDT_HI_W = 12,
    parameter int WDT_LO_W = 17
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic                         run,
    input  logic                         kick,
    input  logic [WDT_HI_W-1:0]          start_hi,
    output logic [WDT_HI_W+WDT_LO_W-1:0] count,
    output logic                         expire
);

    localparam int CNT_W = WDT_HI_W + WDT_LO_W;

    logic [CNT_W-1:0] start_val;
    assign start_val = {start_hi, {WDT_LO_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load || (run && kick)) begin
            count <= start_val;
        end else if (run && (count != '0)) begin
            count <= count - 1'b1;
        end
    end

    // Only meaningful while run is high; the sequencer qualifies it
    assign expire = !kick && (count == '0);

endmodule

// File: rtl/rcfg_seq_fsm.sv
module rcfg_seq_fsm
    import rcfg_pkg::*;
#(
    parameter int BOOT_W = 23
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trigger,
    input  logic              expire,
    input  logic [BOOT_W-1:0] cur_addr,
    input  logic              cur_en,
    output logic              reconfig_req,
    output logic [BOOT_W+1:0] reconfig_addr,
    output logic              commit,
    output logic              revert,
    output logic              wdt_load,
    output logic              wdt_run,
    output logic              fired
);

    seq_state_e state, state_nx;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_FACTORY;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions and outputs
    always_comb begin
        state_nx      = state;
        reconfig_req  = 1'b0;
        reconfig_addr = '0;
        commit        = 1'b0;
        revert        = 1'b0;
        wdt_load      = 1'b0;
        wdt_run       = 1'b0;
        unique case (state)
            ST_FACTORY, ST_USER: begin
                if (trigger) begin
                    commit   = 1'b1;
                    state_nx = ST_LAUNCH;
                end
            end
            ST_ARMED: begin
                wdt_run = 1'b1;
                if (trigger) begin
                    commit   = 1'b1;
                    state_nx = ST_LAUNCH;
                end else if (expire) begin
                    revert   = 1'b1;
                    state_nx = ST_FALLBACK;
                end
            end
            ST_LAUNCH: begin
                reconfig_req  = 1'b1;
                reconfig_addr = {cur_addr, 2'b00};
                wdt_load      = 1'b1;
                if (cur_addr == '0) begin
                    state_nx = ST_FACTORY;
                end else if (cur_en) begin
                    state_nx = ST_ARMED;
                end else begin
                    state_nx = ST_USER;
                end
            end
            ST_FALLBACK: begin
                reconfig_req  = 1'b1;
                reconfig_addr = '0;
                state_nx      = ST_FACTORY;
            end
            default: begin
                state_nx = ST_FACTORY;
            end
        endcase
    end

    // Sticky record of a watchdog fallback
    always_ff @(posedge clk) begin
        if (rst) begin
            fired <= 1'b0;
        end else if (revert) begin
            fired <= 1'b1;
        end
    end

endmodule

// File: rtl/remote_reconfig_ctrl.sv
module remote_reconfig_ctrl
    import rcfg_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BOOT_W   = 23,
    parameter int WDT_HI_W = 12,
    parameter int WDT_LO_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        bus_addr,
    input  logic [1:0]        bus_rsel,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wdt_kick,
    output logic              reconfig_req,
    output logic [BOOT_W+1:0] reconfig_addr
);

    localparam int CNT_W = WDT_HI_W + WDT_LO_W;

    logic                trigger;
    logic                wr_en;
    logic                commit;
    logic                revert;
    logic                wdt_load;
    logic                wdt_armed;
    logic                wdt_expire;
    logic                wdt_fired;
    logic [CNT_W-1:0]    wdt_count;
    logic [BOOT_W-1:0]   cur_addr;
    logic [WDT_HI_W-1:0] cur_tmo;
    logic                cur_en;
    logic [BOOT_W-1:0]   pend_addr;

    assign trigger = bus_we && (bus_addr == RID_RECONF) && bus_wdata[0];
    assign wr_en   = bus_we && (bus_rsel == RS_CUR);

    rcfg_param_sets #(
        .DATA_W   (DATA_W),
        .BOOT_W   (BOOT_W),
        .WDT_HI_W (WDT_HI_W)
    ) u_sets (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_reg    (bus_addr),
        .wr_data   (bus_wdata),
        .rd_en     (bus_re),
        .rd_reg    (bus_addr),
        .rd_src    (bus_rsel),
        .commit    (commit),
        .revert    (revert),
        .st_fired  (wdt_fired),
        .st_armed  (wdt_armed),
        .rdata     (bus_rdata),
        .cur_addr  (cur_addr),
        .cur_tmo   (cur_tmo),
        .cur_en    (cur_en),
        .pend_addr (pend_addr)
    );

    rcfg_watchdog #(
        .WDT_HI_W (WDT_HI_W),
        .WDT_LO_W (WDT_LO_W)
    ) u_wdt (
        .clk      (clk),
        .rst      (rst),
        .load     (wdt_load),
        .run      (wdt_armed),
        .kick     (wdt_kick),
        .start_hi (cur_tmo),
        .count    (wdt_count),
        .expire   (wdt_expire)
    );

    rcfg_seq_fsm #(
        .BOOT_W (BOOT_W)
    ) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .trigger       (trigger),
        .expire        (wdt_expire),
        .cur_addr      (cur_addr),
        .cur_en        (cur_en),
        .reconfig_req  (reconfig_req),
        .reconfig_addr (reconfig_addr),
        .commit        (commit),
        .revert        (revert),
        .wdt_load      (wdt_load),
        .wdt_run       (wdt_armed),
        .fired         (wdt_fired)
    );

endmodule

// File: rtl/rcfg_checker.sv
module rcfg_checker #(
    parameter int BOOT_W   = 23,
    parameter int WDT_HI_W = 12,
    parameter int WDT_LO_W = 17
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         bus_we,
    input logic [1:0]                   bus_rsel,
    input logic                         wdt_kick,
    input logic                         reconfig_req,
    input logic [BOOT_W+1:0]            reconfig_addr,
    input logic [BOOT_W-1:0]            cur_addr,
    input logic [WDT_HI_W-1:0]          cur_tmo,
    input logic                         cur_en,
    input logic [BOOT_W-1:0]            pend_addr,
    input logic                         wdt_armed,
    input logic                         wdt_fired,
    input logic [WDT_HI_W+WDT_LO_W-1:0] wdt_count
);

    localparam int CNT_W = WDT_HI_W + WDT_LO_W;

    logic [CNT_W-1:0] start_full;
    assign start_full = {cur_tmo, {WDT_LO_W{1'b0}}};

    assert_reset_state_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!reconfig_req && cur_addr == '0 && !wdt_fired && !wdt_armed));

    assert_write_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_rsel != 2'b00) |=> $stable(pend_addr));

    assert_req_single_R6: assert property (@(posedge clk) disable iff (rst)
        reconfig_req |=> !reconfig_req);

    assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
        wdt_armed |-> (wdt_count <= start_full));

    assert_kick_reload_R8: assert property (@(posedge clk) disable iff (rst)
        (wdt_armed && wdt_kick && !bus_we) |=> (wdt_count == start_full));

    assert_fallback_target_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(wdt_fired) |-> (reconfig_req && reconfig_addr == '0));

    assert_fired_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        wdt_fired |=> wdt_fired);

    assert_arm_user_only_R10: assert property (@(posedge clk) disable iff (rst)
        wdt_armed |-> (cur_en && cur_addr != '0));

endmodule

bind remote_reconfig_ctrl rcfg_checker #(
    .BOOT_W   (BOOT_W),
    .WDT_HI_W (WDT_HI_W),
    .WDT_LO_W (WDT_LO_W)
) u_rcfg_checker (
    .clk           (clk),
    .rst           (rst),
    .bus_we        (bus_we),
    .bus_rsel      (bus_rsel),
    .wdt_kick      (wdt_kick),
    .reconfig_req  (reconfig_req),
    .reconfig_addr (reconfig_addr),
    .cur_addr      (cur_addr),
    .cur_tmo       (cur_tmo),
    .cur_en        (cur_en),
    .pend_addr     (pend_addr),
    .wdt_armed     (wdt_armed),
    .wdt_fired     (wdt_fired),
    .wdt_count     (wdt_count)
);

// File: tb/remote_reconfig_ctrl_bench.sv
`timescale 1ns/1ps
module remote_reconfig_ctrl_bench;

    localparam int DATA_W   = 32;
    localparam int BOOT_W   = 23;
    localparam int WDT_HI_W = 12;
    localparam int WDT_LO_W = 4;
    localparam int TMO      = 3;
    localparam int START    = TMO << WDT_LO_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [2:0]        bus_addr = '0;
    logic [1:0]        bus_rsel = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic              bus_we = 1'b0;
    logic              bus_re = 1'b0;
    logic [DATA_W-1:0] bus_rdata;
    logic              wdt_kick = 1'b0;
    logic              reconfig_req;
    logic [BOOT_W+1:0] reconfig_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int req_count = 0;
    int req_cyc_last = 0;
    int req_cyc_prev = 0;
    logic [BOOT_W+1:0] req_addr_last = '0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    remote_reconfig_ctrl #(
        .DATA_W   (DATA_W),
        .BOOT_W   (BOOT_W),
        .WDT_HI_W (WDT_HI_W),
        .WDT_LO_W (WDT_LO_W)
    ) u_remote_reconfig_ctrl (
        .clk           (clk),
        .rst           (rst),
        .bus_addr      (bus_addr),
        .bus_rsel      (bus_rsel),
        .bus_wdata     (bus_wdata),
        .bus_we        (bus_we),
        .bus_re        (bus_re),
        .bus_rdata     (bus_rdata),
        .wdt_kick      (wdt_kick),
        .reconfig_req  (reconfig_req),
        .reconfig_addr (reconfig_addr)
    );

    // Request monitor: reads the value held before this edge
    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst && reconfig_req) begin
            req_count     = req_count + 1;
            req_cyc_prev  = req_cyc_last;
            req_cyc_last  = cyc;
            req_addr_last = reconfig_addr;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [1:0] rs, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rsel = rs; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [1:0] rs, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rsel = rs; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 no request after reset", req_count, 0);
        bus_read(3'd0, 2'b00, d); check("R1 current boot", d, 0);
        bus_read(3'd1, 2'b01, d); check("R1 previous timeout", d, 0);
        bus_read(3'd2, 2'b11, d); check("R1 pending enable", d, 0);
        bus_read(3'd4, 2'b00, d); check("R1 status", d, 0);
    endtask

    task automatic t_write_readback();
        logic [31:0] d;
        bus_write(3'd0, 2'b00, 32'h0002_0000);
        bus_write(3'd1, 2'b00, 32'h0000_FABC);
        bus_write(3'd2, 2'b00, 32'h0000_0003);
        bus_read(3'd0, 2'b11, d); check("R2 pending boot readback", d, 32'h0002_0000);
        bus_read(3'd1, 2'b11, d); check("R5 timeout keeps 12 bits", d, 32'h0000_0ABC);
        bus_read(3'd2, 2'b11, d); check("R5 enable keeps bit 0", d, 1);
        bus_read(3'd0, 2'b00, d); check("R3 current untouched by write", d, 0);
        bus_read(3'd0, 2'b10, d); check("R3 selector 10 reads zero", d, 0);
        bus_read(3'd6, 2'b11, d); check("R3 unused index reads zero", d, 0);
        bus_write(3'd0, 2'b01, 32'h0000_1234);
        bus_write(3'd0, 2'b11, 32'h0000_5678);
        bus_read(3'd0, 2'b11, d); check("R2 write with nonzero selector ignored", d, 32'h0002_0000);
        bus_write(3'd2, 2'b00, 32'h0);
    endtask

    task automatic t_launch_unwatched();
        logic [31:0] d;
        int n0;
        n0 = req_count;
        bus_write(3'd3, 2'b00, 32'h0);
        idle(3);
        check("R6 writing 0 to reconfigure does nothing", req_count, n0);
        bus_write(3'd3, 2'b01, 32'h1);
        idle(2);
        check("R6 one request per trigger", req_count, n0 + 1);
        check("R4 request byte address", req_addr_last, 25'h008_0000);
        bus_read(3'd0, 2'b00, d); check("R6 current took pending boot", d, 32'h0002_0000);
        bus_read(3'd1, 2'b00, d); check("R6 current took pending timeout", d, 32'h0ABC);
        bus_read(3'd0, 2'b01, d); check("R6 previous took old current", d, 0);
        bus_read(3'd4, 2'b00, d); check("R10 status with enable off", d, 0);
        idle(100);
        check("R10 no fallback with enable off", req_count, n0 + 1);
    endtask

    task automatic t_expiry();
        logic [31:0] d;
        int n0;
        bus_write(3'd0, 2'b00, 32'h0003_0000);
        bus_write(3'd1, 2'b00, TMO);
        bus_write(3'd2, 2'b00, 32'h1);
        n0 = req_count;
        bus_write(3'd3, 2'b00, 32'h1);
        bus_read(3'd4, 2'b00, d); check("R9 armed status bit", d, 32'h2);
        bus_read(3'd0, 2'b01, d); check("R6 previous holds earlier user set", d, 32'h0002_0000);
        idle(START + 10);
        check("R7 launch plus fallback requests", req_count, n0 + 2);
        check("R7 fallback latency start+2", req_cyc_last - req_cyc_prev, START + 2);
        check("R7 fallback byte address", req_addr_last, 0);
        bus_read(3'd0, 2'b00, d); check("R9 current boot cleared", d, 0);
        bus_read(3'd1, 2'b00, d); check("R9 current timeout cleared", d, 0);
        bus_read(3'd2, 2'b00, d); check("R9 current enable cleared", d, 0);
        bus_read(3'd0, 2'b01, d); check("R9 previous holds failed set", d, 32'h0003_0000);
        bus_read(3'd4, 2'b00, d); check("R9 fired set, armed clear", d, 32'h1);
    endtask

    task automatic t_kick();
        logic [31:0] d;
        int n0;
        n0 = req_count;
        bus_write(3'd3, 2'b00, 32'h1);
        for (int k = 0; k < 15; k++) begin
            idle(9);
            wdt_kick = 1'b1;
            @(negedge clk);
            wdt_kick = 1'b0;
        end
        check("R8 kicks hold off fallback", req_count, n0 + 1);
        bus_read(3'd4, 2'b00, d); check("R8 still armed while kicked", d, 32'h3);
        idle(START + 10);
        check("R8 fallback once kicks stop", req_count, n0 + 2);
        check("R8 fallback address zero", req_addr_last, 0);
    endtask

    task automatic t_factory_enabled();
        logic [31:0] d;
        int n0;
        bus_write(3'd0, 2'b00, 32'h0);
        n0 = req_count;
        bus_write(3'd3, 2'b00, 32'h1);
        idle(2);
        check("R6 request to factory", req_count, n0 + 1);
        check("R4 factory byte address", req_addr_last, 0);
        bus_read(3'd4, 2'b00, d); check("R10 factory never armed", d, 32'h1);
        idle(START + 20);
        check("R10 no fallback from factory", req_count, n0 + 1);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog timeout actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_write_readback();
        t_launch_unwatched();
        t_expiry();
        t_kick();
        t_factory_enabled();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule